// File: doc/BRIEF.md
# Three-Cell Overcharge Guard Controller

This block is the digital decision logic that protects a stack of three series cells against overcharge. It receives per-cell comparator results from an analog front end and produces a charge-blocking level and one bleed enable per cell. The front end reports, for each cell, whether it sits at or above the overcharge trip level and whether it sits at or below the lower release level. It also reports a few system conditions: a discharge-current indication, a remote enable level, cell-monitor activity, a shorted-cell indication and a low-supply indication.

An overcharge is recognised only after a condition has been held for a set number of timebase ticks. Once recognised, the guard stops charging and bleeds the cells that are over the trip level. Each bleed ends as soon as its own cell reaches the release level. Charging resumes only when every cell is back at its release level, or when discharge current is seen. All asynchronous flags are synchronised inside the block. The timebase tick is a single-cycle pulse that comes from the surrounding clock domain.

Top module: `ovc_guard`

## Requirements
- R1: If at least one cell's trip flag is held through `QUAL_TICKS` consecutive tick pulses (default 23), `chg_block` goes high. It stays low after one tick fewer.
- R2: If every trip flag drops before the count completes, the count returns to zero. A later condition then needs the full `QUAL_TICKS` ticks again.
- R3: When an overcharge is recognised, `bleed_en[i]` goes high for each cell i whose trip flag is set. Bit i of `bleed_en` belongs to bit i of `trip_flag` and `rel_flag`.
- R4: While tripped, `bleed_en[i]` goes low when `rel_flag[i]` is set and `trip_flag[i]` is clear. The other cells' bleed enables are not affected.
- R5: While tripped, `chg_block` stays high until every bit of `rel_flag` is set. It then returns low and all bleed enables clear.
- R6: While tripped, a high `dis_seen` clears `chg_block` and all bleed enables together.
- R7: While `mon_busy` is high, every `bleed_en` bit is low. The tripped state and its per-cell bleed memory are kept and reappear when `mon_busy` falls.
- R8: While `remote_on` is low, `chg_block` is high whatever the overcharge state.
- R9: A high `short_cell` forces `chg_block` high unless `low_supply` is also high. In that case the short indication has no effect, so a fully depleted cell can be charged.
- R10: A synchronous `rst` clears the tripped state, every bleed enable and the qualification count. Every flag input passes `SYNC_STAGES` flops (default 2) before it is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Single-cycle timebase pulse that advances the qualification count |
| trip_flag | input | N_CELLS | Per-cell flag: voltage at or above the overcharge trip level |
| rel_flag | input | N_CELLS | Per-cell flag: voltage at or below the release level |
| dis_seen | input | 1 | Discharge current detected across the charge switch |
| remote_on | input | 1 | Pack-attached enable; low forces charge blocking |
| mon_busy | input | 1 | Cell-voltage monitor active; suppresses bleeding |
| short_cell | input | 1 | Some cell is near zero volts |
| low_supply | input | 1 | Stack supply is very low; lifts the short-cell block |
| chg_block | output | 1 | High to turn the charge switch off |
| bleed_en | output | N_CELLS | Per-cell bleed current enable |

## Verification
The qualification path is tested with a condition held for exactly the full tick count and for one tick short of it. It is also tested with a condition that drops out partway and then returns, which shows whether the count restarts or accumulates. Release is tested with cells crossing back one at a time, which separates per-cell bleed release from the all-cells rule for charge release. Discharge, monitor activity, remote disable and the short/low-supply pair are each applied against a tripped or idle state. This shows which of them override which, and the reset test is applied to a latched trip.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
   typedef enum logic {
      GUARD_IDLE = 1'b0,
      GUARD_TRIP = 1'b1
   } guard_state_e;

   // Number of single-bit system flags that ride alongside the per-cell flags.
   localparam int unsigned SYS_FLAGS = 5;
endpackage

// File: rtl/ovc_sync_bank.sv
module ovc_sync_bank #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (WIDTH < 1) begin : g_bad_width
      $error("ovc_sync_bank: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_sync = d_async;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign q_sync = stage_q[STAGES-1];
   end
endmodule

// File: rtl/ovc_qual_timer.sv
module ovc_qual_timer #(
   parameter int unsigned QUAL_TICKS = 23
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic arm,
   output logic expired
);
   localparam int unsigned CNT_W = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_TICKS - 1);

   if (QUAL_TICKS < 1) begin : g_bad_ticks
      $error("ovc_qual_timer: QUAL_TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   assign expired = arm && tick && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst || !arm) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   // R2: any dropout of the armed condition restarts the count
   p_restart_on_drop_r2 : assert property (@(posedge clk) disable iff (rst)
      !arm |=> cnt_q == '0);

   // R1: count never passes the programmed limit
   p_count_bound_r1 : assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);

   // R1: without a tick the count holds
   p_hold_no_tick_r1 : assert property (@(posedge clk) disable iff (rst)
      arm && !tick |=> $stable(cnt_q));
endmodule

// File: rtl/ovc_trip_ctrl.sv
module ovc_trip_ctrl
   import ovc_pkg::*;
#(
   parameter int unsigned N_CELLS = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               qualified,
   input  logic [N_CELLS-1:0] trip_s,
   input  logic [N_CELLS-1:0] rel_s,
   input  logic               dis_s,
   output logic               tripped,
   output logic [N_CELLS-1:0] bleed_mem
);
   guard_state_e state_q;
   logic         all_released;

   assign all_released = &rel_s;
   assign tripped      = (state_q == GUARD_TRIP);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= GUARD_IDLE;
         bleed_mem <= '0;
      end else begin
         case (state_q)
            GUARD_IDLE: begin
               if (qualified) begin
                  state_q   <= GUARD_TRIP;
                  bleed_mem <= trip_s;
               end
            end
            GUARD_TRIP: begin
               if (dis_s || all_released) begin
                  state_q   <= GUARD_IDLE;
                  bleed_mem <= '0;
               end else begin
                  for (int i = 0; i < N_CELLS; i++) begin
                     if (trip_s[i])     bleed_mem[i] <= 1'b1;
                     else if (rel_s[i]) bleed_mem[i] <= 1'b0;
                  end
               end
            end
            default: state_q <= GUARD_IDLE;
         endcase
      end
   end

   // R3: bleed memory only exists while tripped
   p_bleed_only_tripped_r3 : assert property (@(posedge clk) disable iff (rst)
      !tripped |-> bleed_mem == '0);

   // R5: all cells released ends the trip
   p_release_all_r5 : assert property (@(posedge clk) disable iff (rst)
      tripped && all_released |=> !tripped);

   // R6: discharge clears everything at once
   p_discharge_clear_r6 : assert property (@(posedge clk) disable iff (rst)
      tripped && dis_s |=> !tripped && bleed_mem == '0);

   for (genvar g = 0; g < N_CELLS; g++) begin : g_cell_chk
      // R4: each cell releases its own bleed
      p_cell_release_r4 : assert property (@(posedge clk) disable iff (rst)
         tripped && rel_s[g] && !trip_s[g] |=> !bleed_mem[g]);
   end
endmodule

// File: rtl/ovc_guard.sv
module ovc_guard
   import ovc_pkg::*;
#(
   parameter int unsigned N_CELLS     = 3,
   parameter int unsigned QUAL_TICKS  = 23,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic [N_CELLS-1:0] trip_flag,
   input  logic [N_CELLS-1:0] rel_flag,
   input  logic               dis_seen,
   input  logic               remote_on,
   input  logic               mon_busy,
   input  logic               short_cell,
   input  logic               low_supply,
   output logic               chg_block,
   output logic [N_CELLS-1:0] bleed_en
);
   localparam int unsigned FLAG_W = 2 * N_CELLS + SYS_FLAGS;

   if (N_CELLS < 1) begin : g_bad_cells
      $error("ovc_guard: N_CELLS must be at least 1");
   end

   logic [FLAG_W-1:0]  raw_flags, syn_flags;
   logic [N_CELLS-1:0] trip_s, rel_s, bleed_mem;
   logic dis_s, remote_s, mon_s, short_s, lowsup_s;
   logic tripped, qualified, arm;

   assign raw_flags = {low_supply, short_cell, mon_busy, remote_on, dis_seen,
                       rel_flag, trip_flag};

   ovc_sync_bank #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (raw_flags),
      .q_sync  (syn_flags)
   );

   assign trip_s   = syn_flags[N_CELLS-1:0];
   assign rel_s    = syn_flags[2*N_CELLS-1:N_CELLS];
   assign dis_s    = syn_flags[2*N_CELLS];
   assign remote_s = syn_flags[2*N_CELLS+1];
   assign mon_s    = syn_flags[2*N_CELLS+2];
   assign short_s  = syn_flags[2*N_CELLS+3];
   assign lowsup_s = syn_flags[2*N_CELLS+4];

   assign arm = (|trip_s) && !tripped;

   ovc_qual_timer #(.QUAL_TICKS(QUAL_TICKS)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .arm     (arm),
      .expired (qualified)
   );

   ovc_trip_ctrl #(.N_CELLS(N_CELLS)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .qualified (qualified),
      .trip_s    (trip_s),
      .rel_s     (rel_s),
      .dis_s     (dis_s),
      .tripped   (tripped),
      .bleed_mem (bleed_mem)
   );

   assign chg_block = tripped || !remote_s || (short_s && !lowsup_s);
   assign bleed_en  = mon_s ? '0 : bleed_mem;

   // R1: a qualified trip is visible at the charge-block output next cycle
   p_trip_blocks_r1 : assert property (@(posedge clk) disable iff (rst)
      qualified |=> chg_block);

   // R7: monitor activity keeps every bleed switch off
   p_monitor_quiet_r7 : assert property (@(posedge clk) disable iff (rst)
      mon_s |-> bleed_en == '0);

   // R8: remote disable always blocks charging
   p_remote_block_r8 : assert property (@(posedge clk) disable iff (rst)
      !remote_s |-> chg_block);
endmodule

// File: tb/ovc_guard_test.sv
module ovc_guard_test;
   localparam int N = 3;
   localparam int QT = 23;

   logic clk = 1'b0;
   logic rst, tick, dis_seen, remote_on, mon_busy, short_cell, low_supply;
   logic [N-1:0] trip_flag, rel_flag, bleed_en;
   logic chg_block;

   always #5 clk = ~clk;

   ovc_guard #(.N_CELLS(N), .QUAL_TICKS(QT), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .tick(tick), .trip_flag(trip_flag),
      .rel_flag(rel_flag), .dis_seen(dis_seen), .remote_on(remote_on),
      .mon_busy(mon_busy), .short_cell(short_cell), .low_supply(low_supply),
      .chg_block(chg_block), .bleed_en(bleed_en)
   );

   typedef struct {
      logic       blk;
      logic [N-1:0] bl;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 1'b0;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         tick = 1'b1;
         step(1);
         tick = 1'b0;
      end
   endtask

   task automatic expect_out(input logic blk, input logic [N-1:0] bl, input string tag);
      exp_t e;
      e.blk = blk; e.bl = bl; e.tag = tag;
      exp_q.push_back(e);
      step(1);
   endtask

   task automatic trip_now(input logic [N-1:0] cells);
      trip_flag = cells;
      rel_flag  = '0;
      step(3);
      pulse_ticks(QT);
      step(1);
   endtask

   // Scoreboard monitor
   initial begin
      forever begin
         exp_t e;
         wait (exp_q.size() != 0);
         #1;
         e = exp_q.pop_front();
         n_checks++;
         if (chg_block !== e.blk || bleed_en !== e.bl) begin
            n_errors++;
            $display("FAIL %s: got blk=%b bleed=%b, expected blk=%b bleed=%b",
                     e.tag, chg_block, bleed_en, e.blk, e.bl);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; tick = 1'b0; trip_flag = '0; rel_flag = '0; dis_seen = 1'b0;
      remote_on = 1'b1; mon_busy = 1'b0; short_cell = 1'b0; low_supply = 1'b0;
      step(3);
      rst = 1'b0;
      step(3);
      expect_out(1'b0, 3'b000, "R10 reset state");

      // R1: one tick short, then the last tick
      trip_flag = 3'b010;
      step(3);
      pulse_ticks(QT - 1);
      step(1);
      expect_out(1'b0, 3'b000, "R1 one tick short");
      pulse_ticks(1);
      step(1);
      expect_out(1'b1, 3'b010, "R1 trip after full count");
      rel_flag = 3'b111; trip_flag = '0;
      step(3);
      expect_out(1'b0, 3'b000, "R5 clean release");

      // R2: dropout restarts the count
      rel_flag = '0;
      trip_flag = 3'b001;
      step(3);
      pulse_ticks(10);
      trip_flag = '0;
      step(3);
      trip_flag = 3'b001;
      step(3);
      pulse_ticks(QT - 1);
      step(1);
      expect_out(1'b0, 3'b000, "R2 count restarted after dropout");
      pulse_ticks(1);
      step(1);
      expect_out(1'b1, 3'b001, "R2 trip after fresh full count");
      rel_flag = 3'b111; trip_flag = '0;
      step(3);

      // R3/R4/R5: two cells over, release one at a time
      trip_now(3'b101);
      expect_out(1'b1, 3'b101, "R3 bleed on over cells");
      trip_flag = 3'b100; rel_flag = 3'b001;
      step(3);
      expect_out(1'b1, 3'b100, "R4 cell0 bleed released alone");
      trip_flag = 3'b000; rel_flag = 3'b011;
      step(3);
      expect_out(1'b1, 3'b100, "R5 block held with cell2 not released");
      rel_flag = 3'b111;
      step(3);
      expect_out(1'b0, 3'b000, "R5 all released");

      // R6: discharge clears trip
      trip_now(3'b110);
      expect_out(1'b1, 3'b110, "R6 tripped before discharge");
      trip_flag = '0;
      dis_seen = 1'b1;
      step(3);
      expect_out(1'b0, 3'b000, "R6 discharge clears");
      dis_seen = 1'b0;
      step(3);
      expect_out(1'b0, 3'b000, "R6 stays clear after discharge");

      // R7: monitor suppresses bleeding, state kept
      mon_busy = 1'b1;
      step(3);
      trip_now(3'b011);
      expect_out(1'b1, 3'b000, "R7 monitor holds bleed off");
      mon_busy = 1'b0;
      step(3);
      expect_out(1'b1, 3'b011, "R7 bleed returns after monitor");

      // R10: reset clears a latched trip
      trip_flag = '0;
      step(3);
      expect_out(1'b1, 3'b011, "R10 trip latched before reset");
      rst = 1'b1;
      step(1);
      rst = 1'b0;
      step(3);
      expect_out(1'b0, 3'b000, "R10 reset clears trip");

      // R8: remote disable
      remote_on = 1'b0;
      step(3);
      expect_out(1'b1, 3'b000, "R8 remote low blocks");
      remote_on = 1'b1;
      step(3);
      expect_out(1'b0, 3'b000, "R8 remote high unblocks");

      // R9: short cell and low supply
      short_cell = 1'b1;
      step(3);
      expect_out(1'b1, 3'b000, "R9 short cell blocks");
      low_supply = 1'b1;
      step(3);
      expect_out(1'b0, 3'b000, "R9 low supply lifts short block");
      short_cell = 1'b0; low_supply = 1'b0;
      step(3);
      expect_out(1'b0, 3'b000, "R9 idle after short cleared");

      wait (exp_q.size() == 0);
      step(2);
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule